// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block takes a 25-bit clock-mode word from a register write port and turns it into the controls for an external oscillator and PLL: whether the PLL runs, the reference input divider, the feedback multiplier, the post-divider ratio and the drive and load mode of the crystal pins. It also owns the clock-source selection. It changes that selection only when it is safe to do so.

When a word selects the crystal or the PLL as the new source, the oscillator and PLL controls take effect right away, but the source selection stays where it was. A settle interval of `SETTLE_CYCLES` clock cycles then runs, and the source select moves only when it ends. The default interval is 200000 cycles, which is 10 ms at 20 MHz. A word that selects one of the two internal RC sources switches at once.

While a settle wait is pending, `busy` is high. Every change of the source select comes with a one-cycle `done` pulse.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset: `src_sel`=0 (fast RC), `busy`=0, `done`=0, `pll_on`=0, `osc_drive`=0, `ref_div`=1, `fb_mul`=1 and `out_div`=2. These are the decoded values of an all-zero word.
- R2: One cycle after a write, `pll_on` equals word bit 24.
- R3: One cycle after a write, `ref_div` equals word bits 23:18 plus one, giving dividers 1 to 64.
- R4: One cycle after a write, `fb_mul` equals word bits 17:8 plus one, giving multipliers 1 to 1024.
- R5: One cycle after a write, `out_div` follows the code p in word bits 7:4. p=15 gives 1, and every other p gives 2*(p+1), so the even ratios 2 to 30.
- R6: One cycle after a write, `osc_drive` equals word bits 3:2. The codes are 0 off and floating, 1 driven with no load caps, 2 for 15 pF per pin and 3 for 30 pF per pin.
- R7: A write whose bits 1:0 are 2 (crystal) or 3 (PLL) leaves `src_sel` unchanged for SETTLE_CYCLES-1 cycles after the write. `src_sel` takes the new value SETTLE_CYCLES cycles after the write edge.
- R8: A write whose bits 1:0 are 0 (fast RC) or 1 (slow RC) sets `src_sel` in the next cycle, and `busy` stays low.
- R9: A write during a settle wait restarts the wait, and the latest word's source wins. If that word selects an RC source, the wait is cancelled and the source switches in the next cycle.
- R10: `busy` is high from the cycle after a crystal or PLL write until the cycle in which `src_sel` updates. `done` is high for exactly that one update cycle and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the mode word |
| cfg_word | input | 25 | Clock-mode word |
| pll_on | output | 1 | PLL enable |
| ref_div | output | 7 | Reference input divide ratio |
| fb_mul | output | 11 | VCO feedback multiply ratio |
| out_div | output | 5 | Post-divider ratio |
| osc_drive | output | 2 | Crystal pin drive and load mode |
| src_sel | output | 2 | Committed clock source |
| busy | output | 1 | Settle wait in progress |
| done | output | 1 | One-cycle pulse on a source update |

## Verification
The bench builds the block with `SETTLE_CYCLES` = 12. This keeps every settle wait short enough to count edge by edge. The exact switch edge, a restart partway through a wait and a cancel by an RC write can then all be observed many times in one run. The field corners are covered as well: multiplier 1024, divider 64, and every post-divider code including the divide-by-one code.

// File: rtl/clk_switch_pkg.sv
`timescale 1ns/1ps
package clk_switch_pkg;

    localparam int WORD_W = 25;

    typedef enum logic [1:0] {
        SRC_RC_FAST = 2'd0,
        SRC_RC_SLOW = 2'd1,
        SRC_XTAL    = 2'd2,
        SRC_PLL     = 2'd3
    } src_e;

    typedef struct packed {
        logic        pll_on;
        logic [6:0]  ref_div;
        logic [10:0] fb_mul;
        logic [4:0]  out_div;
        logic [1:0]  osc_drive;
    } osc_ctrl_t;

    // decoded controls of an all-zero mode word
    localparam osc_ctrl_t CTRL_RESET = '{
        pll_on:    1'b0,
        ref_div:   7'd1,
        fb_mul:    11'd1,
        out_div:   5'd2,
        osc_drive: 2'd0
    };

    // internal RC sources need no settle time
    function automatic logic is_rc(input src_e s);
        return (s == SRC_RC_FAST) || (s == SRC_RC_SLOW);
    endfunction

endpackage

// File: rtl/clk_word_decode.sv
`timescale 1ns/1ps
module clk_word_decode
    import clk_switch_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output osc_ctrl_t         ctrl,
    output src_e              target
);
    logic [5:0] div_f;
    logic [9:0] mul_f;
    logic [3:0] post_f;

    always_comb begin
        div_f  = word[23:18];
        mul_f  = word[17:8];
        post_f = word[7:4];

        ctrl.pll_on    = word[24];
        ctrl.ref_div   = {1'b0, div_f} + 7'd1;
        ctrl.fb_mul    = {1'b0, mul_f} + 11'd1;
        // the all-ones code means no division; other codes give even ratios
        ctrl.out_div   = (post_f == 4'hF) ? 5'd1 : ({post_f, 1'b0} + 5'd2);
        ctrl.osc_drive = word[3:2];
        target         = src_e'(word[1:0]);
    end
endmodule

// File: rtl/settle_timer.sv
`timescale 1ns/1ps
module settle_timer #(
    parameter int SETTLE_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic running,
    output logic expired
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = LOAD_VAL;
        end else if (abort) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign running = tmr_q.run;
    assign expired = tmr_q.run && (tmr_q.cnt == '0) && !start && !abort;
endmodule

// File: rtl/clk_switch_seq.sv
`timescale 1ns/1ps
module clk_switch_seq
    import clk_switch_pkg::*;
#(
    parameter int SETTLE_CYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_word,
    output logic              pll_on,
    output logic [6:0]        ref_div,
    output logic [10:0]       fb_mul,
    output logic [4:0]        out_div,
    output logic [1:0]        osc_drive,
    output logic [1:0]        src_sel,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        osc_ctrl_t ctrl;
        src_e      src;
        src_e      pend;
        logic      done;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        ctrl: CTRL_RESET,
        src:  SRC_RC_FAST,
        pend: SRC_RC_FAST,
        done: 1'b0
    };

    seq_t      seq_d, seq_q;
    osc_ctrl_t dec_ctrl;
    src_e      dec_target;
    logic      tmr_start, tmr_abort, tmr_running, tmr_expired;

    clk_word_decode u_dec (
        .word   (cfg_word),
        .ctrl   (dec_ctrl),
        .target (dec_target)
    );

    settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .abort   (tmr_abort),
        .running (tmr_running),
        .expired (tmr_expired)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_start  = 1'b0;
        tmr_abort  = 1'b0;
        if (cfg_wr) begin
            // oscillator and PLL fields always apply at once
            seq_d.ctrl = dec_ctrl;
            if (is_rc(dec_target)) begin
                seq_d.src  = dec_target;
                seq_d.done = 1'b1;
                tmr_abort  = 1'b1;
            end else begin
                seq_d.pend = dec_target;
                tmr_start  = 1'b1;
            end
        end else if (tmr_expired) begin
            seq_d.src  = seq_q.pend;
            seq_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pll_on    = seq_q.ctrl.pll_on;
    assign ref_div   = seq_q.ctrl.ref_div;
    assign fb_mul    = seq_q.ctrl.fb_mul;
    assign out_div   = seq_q.ctrl.out_div;
    assign osc_drive = seq_q.ctrl.osc_drive;
    assign src_sel   = seq_q.src;
    assign busy      = tmr_running;
    assign done      = seq_q.done;
endmodule

// File: rtl/clk_switch_seq_chk.sv
`timescale 1ns/1ps
module clk_switch_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [24:0] cfg_word,
    input logic        pll_on,
    input logic [6:0]  ref_div,
    input logic [10:0] fb_mul,
    input logic [4:0]  out_div,
    input logic [1:0]  osc_drive,
    input logic [1:0]  src_sel,
    input logic        busy,
    input logic        done
);
    // R2
    pll_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> pll_on == $past(cfg_word[24]));

    // R3
    ref_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ref_div == {1'b0, $past(cfg_word[23:18])} + 7'd1);

    // R4
    fb_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> fb_mul == {1'b0, $past(cfg_word[17:8])} + 11'd1);

    // R5
    out_div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (($past(cfg_word[7:4]) == 4'hF) ? (out_div == 5'd1)
                    : (out_div[0] == 1'b0 && out_div >= 5'd2 && out_div <= 5'd30)));

    // R6
    osc_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> osc_drive == $past(cfg_word[3:2]));

    // R7
    slow_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_word[1]) |=> busy && $stable(src_sel));

    // R8
    rc_src_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_word[1]) |=> (src_sel == $past(cfg_word[1:0])) && !busy && done);

    // R10
    src_change_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_sel) |-> done);

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind clk_switch_seq clk_switch_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_word  (cfg_word),
    .pll_on    (pll_on),
    .ref_div   (ref_div),
    .fb_mul    (fb_mul),
    .out_div   (out_div),
    .osc_drive (osc_drive),
    .src_sel   (src_sel),
    .busy      (busy),
    .done      (done)
);

// File: tb/clk_switch_seq_test.sv
`timescale 1ns/1ps
module clk_switch_seq_test;
    localparam int S  = 12;
    localparam int WD = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [24:0] cfg_word = '0;
    logic        pll_on;
    logic [6:0]  ref_div;
    logic [10:0] fb_mul;
    logic [4:0]  out_div;
    logic [1:0]  osc_drive;
    logic [1:0]  src_sel;
    logic        busy;
    logic        done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;
    bit cmp_on = 0;

    always #2.5 clk = ~clk;

    clk_switch_seq #(.SETTLE_CYCLES(S)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .pll_on(pll_on), .ref_div(ref_div), .fb_mul(fb_mul), .out_div(out_div),
        .osc_drive(osc_drive), .src_sel(src_sel), .busy(busy), .done(done)
    );

    // behavioural reference model
    int m_pll, m_div, m_mul, m_post, m_drv, m_src, m_pend, m_busy, m_cnt, m_done;

    function automatic int post_ratio(input int p);
        return (p == 15) ? 1 : 2 * (p + 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pll = 0; m_div = 1; m_mul = 1; m_post = 2; m_drv = 0;
            m_src = 0; m_pend = 0; m_busy = 0; m_cnt = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (cfg_wr) begin
                m_pll  = int'(cfg_word[24]);
                m_div  = int'(cfg_word[23:18]) + 1;
                m_mul  = int'(cfg_word[17:8]) + 1;
                m_post = post_ratio(int'(cfg_word[7:4]));
                m_drv  = int'(cfg_word[3:2]);
                if (cfg_word[1:0] < 2) begin
                    m_src = int'(cfg_word[1:0]); m_busy = 0; m_done = 1;
                end else begin
                    m_pend = int'(cfg_word[1:0]); m_busy = 1; m_cnt = S - 1;
                end
            end else if (m_busy == 1) begin
                if (m_cnt == 0) begin
                    m_src = m_pend; m_busy = 0; m_done = 1;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(int'(pll_on),    m_pll,  "R2 pll_on vs model");
            chk(int'(ref_div),   m_div,  "R3 ref_div vs model");
            chk(int'(fb_mul),    m_mul,  "R4 fb_mul vs model");
            chk(int'(out_div),   m_post, "R5 out_div vs model");
            chk(int'(osc_drive), m_drv,  "R6 osc_drive vs model");
            chk(int'(src_sel),   m_src,  "R7 src_sel vs model");
            chk(int'(busy),      m_busy, "R10 busy vs model");
            chk(int'(done),      m_done, "R10 done vs model");
        end
    end

    function automatic logic [24:0] mk(input bit pll, input int dv, input int ml,
                                       input int pc, input int dr, input int src);
        return {pll, 6'(dv), 10'(ml), 4'(pc), 2'(dr), 2'(src)};
    endfunction

    task automatic wr(input logic [24:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_word = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD);
            finish_run();
        end
    end

    initial begin
        idle(3);
        // R1 reset state
        chk(int'(src_sel), 0, "R1 src_sel reset");
        chk(int'(busy), 0, "R1 busy reset");
        chk(int'(done), 0, "R1 done reset");
        chk(int'(pll_on), 0, "R1 pll_on reset");
        chk(int'(ref_div), 1, "R1 ref_div reset");
        chk(int'(fb_mul), 1, "R1 fb_mul reset");
        chk(int'(out_div), 2, "R1 out_div reset");
        chk(int'(osc_drive), 0, "R1 osc_drive reset");
        rst_n = 1'b1;
        cmp_on = 1;
        idle(2);

        // R7 PLL switch: fields now, source after S cycles
        wr(mk(1, 3, 71, 0, 2, 3));
        chk(int'(pll_on), 1, "R2 pll_on after write");
        chk(int'(ref_div), 4, "R3 divide by 4");
        chk(int'(fb_mul), 72, "R4 multiply by 72");
        chk(int'(osc_drive), 2, "R6 15pF mode");
        chk(int'(busy), 1, "R10 busy after write");
        chk(int'(src_sel), 0, "R7 source held");
        idle(S - 1);
        chk(int'(src_sel), 0, "R7 source held last wait cycle");
        chk(int'(busy), 1, "R10 busy last wait cycle");
        idle(1);
        chk(int'(src_sel), 3, "R7 source switched to PLL");
        chk(int'(done), 1, "R10 done pulse");
        chk(int'(busy), 0, "R10 busy dropped");
        idle(1);
        chk(int'(done), 0, "R10 done one cycle");

        // R8 RC switch is immediate
        wr(mk(0, 0, 0, 15, 1, 1));
        chk(int'(src_sel), 1, "R8 slow RC now");
        chk(int'(busy), 0, "R8 no busy");
        chk(int'(out_div), 1, "R5 code 15 divides by 1");
        wr(mk(0, 0, 0, 0, 0, 0));
        chk(int'(src_sel), 0, "R8 fast RC now");

        // R9 restart: latest word wins
        wr(mk(1, 1, 10, 1, 3, 3));
        idle(5);
        wr(mk(0, 63, 1023, 14, 3, 2));
        chk(int'(ref_div), 64, "R3 divide by 64");
        chk(int'(fb_mul), 1024, "R4 multiply by 1024");
        chk(int'(out_div), 30, "R5 code 14 divides by 30");
        idle(S - 1);
        chk(int'(src_sel), 0, "R9 restarted wait holds source");
        idle(1);
        chk(int'(src_sel), 2, "R9 latest source crystal");

        // R9 cancel by RC write
        wr(mk(1, 2, 20, 3, 2, 3));
        idle(3);
        wr(mk(1, 2, 20, 3, 2, 1));
        chk(int'(src_sel), 1, "R9 cancel to slow RC");
        chk(int'(busy), 0, "R9 wait cancelled");
        idle(S + 2);
        chk(int'(src_sel), 1, "R9 no late switch");

        // R5 every post-divider code, R6 every drive mode
        for (int p = 0; p < 16; p++) begin
            wr(mk(p[0], p, p * 37, p, p % 4, p % 2));
            chk(int'(out_div), post_ratio(p), "R5 post code sweep");
            chk(int'(osc_drive), p % 4, "R6 drive sweep");
        end

        // back-to-back writes
        wr(mk(1, 5, 5, 5, 1, 2));
        wr(mk(1, 6, 6, 6, 1, 3));
        idle(S + 3);
        chk(int'(src_sel), 3, "R9 back-to-back latest wins");

        idle(2);
        finish_run();
    end
endmodule